// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block interprets the host write cycles of an 8-bit parallel NOR-style flash with a 512K x 8 array split into eight 64 KB sectors. It follows the two-write unlock preamble and the command byte that comes after it. From these it moves between four modes: plain array reads, identification reads, a running sector erase, and a suspended sector erase. When a full erase sequence completes, it starts the erase engine with a one-cycle pulse. It pauses and restarts that engine through a suspend request level.

Reads are single strobes. The returned byte appears on `rdata` with `rd_valid` high one cycle after `rd_en`. The source of that byte depends on the mode. In array mode and suspend mode it is the array byte the surrounding logic presents on `array_data`. In identification mode it is an ID or protect code. During an erase it is a status byte. There is no back-pressure on either strobe. Every write or read strobe is taken in the cycle it is high, so a host must not expect a stall.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `mode` is 0 (array read), and `rd_valid`, `rdata`, `erase_go` and `suspend_req` are 0. `mode` encodes 0 = array read, 1 = identification, 2 = erasing, 3 = erase suspended.
- R2: In array-read mode, a read strobe gives `rd_valid` = 1 in the next cycle, with `rdata` equal to the `array_data` byte present during the strobe.
- R3: The write sequence AAh at address 555h, then 55h at 2AAh, then 90h at any address enters identification mode. Only the low 11 address bits are compared. Reads in that mode may be repeated any number of times.
- R4: In identification mode, a read with address bits [1:0] = 00 returns the manufacturer code A7h, so offsets 00h, 04h, 08h and 0Ch all return it. A read with bits [1:0] = 01 returns the device code 3Eh.
- R5: In identification mode, a read with bits [1:0] = 10 returns 01h if `prot[addr[18:16]]` is set and 00h otherwise. A read with bits [1:0] = 11 returns 00h.
- R6: The byte F0h, written either alone or after the unlock pair, returns the block to array-read mode. Any other write that does not begin a sequence leaves identification mode unchanged.
- R7: Once a sequence has begun, a wrong address or data byte in an unlock write, or an unknown command byte, abandons the sequence and returns the block to array-read mode.
- R8: The sequence unlock pair, 80h, unlock pair, then 30h gives `erase_go` = 1 for exactly one cycle in the cycle after the last write. In that cycle `erase_sector` = addr[18:16] of the 30h write and `mode` = 2.
- R9: While erasing, each read returns 00h or 40h. Bit 6 alternates from read to read, and the first read after `erase_go` returns 00h.
- R10: While erasing, B0h written at any address moves the block to mode 3 with `suspend_req` = 1. Reads in mode 3 return `array_data`.
- R11: 30h written at any address in mode 3 returns the block to mode 2 with `suspend_req` = 0. 30h written in mode 2 is ignored and gives no `erase_go`. A later B0h suspends again.
- R12: In mode 2, a fall of `busy` from 1 to 0 returns the block to mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 19 | Byte address |
| wdata | input | 8 | Write data |
| array_data | input | 8 | Array byte at `addr` |
| prot | input | 8 | Protect bit per sector |
| busy | input | 1 | Erase engine busy |
| rdata | output | 8 | Read data |
| rd_valid | output | 1 | `rdata` valid |
| mode | output | 2 | Current mode |
| erase_go | output | 1 | Start-erase pulse |
| erase_sector | output | 3 | Sector to erase |
| suspend_req | output | 1 | Erase pause request |

## Verification
The command decoder is driven with the correct unlock preambles and with preambles broken at the address or at the data byte. This separates a real abort from a write that merely never started a sequence. Identification reads sweep every aliased manufacturer offset, the device offset, protected and unprotected sectors, and the unused offset, so a wrong alias mask or wrong sector slice shows as a wrong byte. The erase path runs through repeated suspend/resume pairs with a duplicate resume between them. This tells an ignored resume apart from one that restarts the erase or re-pulses the start.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_IDENT = 2'd1,
    MODE_ERASE = 2'd2,
    MODE_SUSP  = 2'd3
  } fmode_e;

  typedef struct packed {
    logic ident;
    logic to_read;
    logic erase;
    logic suspend;
    logic resume;
  } fcmd_t;

  localparam logic [7:0] KEY_A      = 8'hAA;
  localparam logic [7:0] KEY_B      = 8'h55;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_RESET   = 8'hF0;
  localparam logic [7:0] OP_SETUP   = 8'h80;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'h30;
  localparam logic [10:0] LOC_A     = 11'h555;
  localparam logic [10:0] LOC_B     = 11'h2AA;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  fmode_e            mode,
  output fcmd_t             cmd
);
  localparam int STG_W = 3;
  logic [STG_W-1:0] stg_q, stg_d;
  logic [10:0]      lo;
  logic             in_erase;

  assign lo       = addr[10:0];
  assign in_erase = (mode == MODE_ERASE) || (mode == MODE_SUSP);

  always_comb begin
    cmd   = '0;
    stg_d = stg_q;
    if (wr_en) begin
      if (in_erase) begin
        stg_d = '0;
        if (mode == MODE_ERASE && wdata == OP_SUSPEND) cmd.suspend = 1'b1;
        if (mode == MODE_SUSP  && wdata == OP_RESUME)  cmd.resume  = 1'b1;
      end else begin
        case (stg_q)
          3'd0: begin
            if (lo == LOC_A && wdata == KEY_A) stg_d = 3'd1;
            else if (wdata == OP_RESET)        cmd.to_read = 1'b1;
          end
          3'd3: begin
            if (lo == LOC_A && wdata == KEY_A) stg_d = 3'd4;
            else begin stg_d = '0; cmd.to_read = 1'b1; end
          end
          3'd1, 3'd4: begin
            if (lo == LOC_B && wdata == KEY_B) stg_d = stg_q + 3'd1;
            else begin stg_d = '0; cmd.to_read = 1'b1; end
          end
          3'd2: begin
            stg_d = '0;
            case (wdata)
              OP_IDENT: cmd.ident   = 1'b1;
              OP_SETUP: stg_d       = 3'd3;
              default:  cmd.to_read = 1'b1;
            endcase
          end
          default: begin
            stg_d = '0;
            if (wdata == OP_RESUME) cmd.erase   = 1'b1;
            else                    cmd.to_read = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end
endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl
  import flash_cmd_pkg::*;
#(
  parameter int SEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fcmd_t            cmd,
  input  logic [SEC_W-1:0] sec_in,
  input  logic             busy,
  output fmode_e           mode,
  output logic             erase_go,
  output logic [SEC_W-1:0] erase_sector,
  output logic             suspend_req
);
  fmode_e mode_q, mode_d;
  logic   busy_q;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_READ, MODE_IDENT: begin
        if (cmd.erase)        mode_d = MODE_ERASE;
        else if (cmd.ident)   mode_d = MODE_IDENT;
        else if (cmd.to_read) mode_d = MODE_READ;
      end
      MODE_ERASE: begin
        if (cmd.suspend)          mode_d = MODE_SUSP;
        else if (busy_q && !busy) mode_d = MODE_READ;
      end
      default: if (cmd.resume) mode_d = MODE_ERASE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= MODE_READ;
      busy_q       <= 1'b0;
      erase_go     <= 1'b0;
      erase_sector <= '0;
    end else begin
      mode_q   <= mode_d;
      busy_q   <= busy;
      erase_go <= cmd.erase;
      if (cmd.erase) erase_sector <= sec_in;
    end
  end

  assign mode        = mode_q;
  assign suspend_req = (mode_q == MODE_SUSP);
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_cmd_pkg::*;
#(
  parameter int         SECTORS = 8,
  parameter int         SEC_W   = 3,
  parameter logic [7:0] MFR_ID  = 8'hA7,
  parameter logic [7:0] DEV_ID  = 8'h3E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  fmode_e             mode,
  input  logic [1:0]         offs,
  input  logic [SEC_W-1:0]   sec,
  input  logic [7:0]         array_data,
  input  logic [SECTORS-1:0] prot,
  input  logic               erase_go,
  output logic [7:0]         rdata,
  output logic               rd_valid
);
  logic       tog_q;
  logic [7:0] id_byte, sel;

  always_comb begin
    case (offs)
      2'b00:   id_byte = MFR_ID;
      2'b01:   id_byte = DEV_ID;
      2'b10:   id_byte = {7'd0, prot[sec]};
      default: id_byte = 8'h00;
    endcase
    case (mode)
      MODE_IDENT: sel = id_byte;
      MODE_ERASE: sel = {1'b0, tog_q, 6'd0};
      default:    sel = array_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= sel;
      if (erase_go)                          tog_q <= 1'b0;
      else if (rd_en && mode == MODE_ERASE)  tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W  = 19,
  parameter int         SECTORS = 8,
  parameter logic [7:0] MFR_ID  = 8'hA7,
  parameter logic [7:0] DEV_ID  = 8'h3E
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  input  logic [7:0]                 array_data,
  input  logic [SECTORS-1:0]         prot,
  input  logic                       busy,
  output logic [7:0]                 rdata,
  output logic                       rd_valid,
  output logic [1:0]                 mode,
  output logic                       erase_go,
  output logic [$clog2(SECTORS)-1:0] erase_sector,
  output logic                       suspend_req
);
  localparam int SEC_W = $clog2(SECTORS);

  fcmd_t            cmd;
  fmode_e           mode_e;
  logic [SEC_W-1:0] sec;

  assign sec  = addr[ADDR_W-1 -: SEC_W];
  assign mode = mode_e;

  flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .mode(mode_e), .cmd(cmd)
  );

  flash_mode_ctl #(.SEC_W(SEC_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .sec_in(sec), .busy(busy),
    .mode(mode_e), .erase_go(erase_go), .erase_sector(erase_sector),
    .suspend_req(suspend_req)
  );

  flash_rd_mux #(.SECTORS(SECTORS), .SEC_W(SEC_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mode(mode_e), .offs(addr[1:0]),
    .sec(sec), .array_data(array_data), .prot(prot), .erase_go(erase_go),
    .rdata(rdata), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [1:0] mode,
  input logic       erase_go,
  input logic       suspend_req,
  input logic       rd_valid
);
  // R2
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R2
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R8
  erase_go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go);
  // R8
  erase_go_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> mode == 2'd2);
  // R10
  suspend_from_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_req) |-> $past(mode) == 2'd2);
  // R11
  dup_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && wr_en && wdata == 8'h30) |=> (mode == 2'd2 && !erase_go) || mode == 2'd0);
  // R6
  ident_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 |=> mode == 2'd1 || mode == 2'd0 || mode == 2'd2);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
  .mode(mode), .erase_go(erase_go), .suspend_req(suspend_req), .rd_valid(rd_valid)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, busy = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0, array_data, rdata;
  logic [7:0]  prot = 8'b0010_0100;
  logic        rd_valid, erase_go, suspend_req;
  logic [1:0]  mode;
  logic [2:0]  erase_sector;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign array_data = addr[7:0] ^ 8'h5A;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .array_data(array_data), .prot(prot), .busy(busy),
    .rdata(rdata), .rd_valid(rd_valid), .mode(mode), .erase_go(erase_go),
    .erase_sector(erase_sector), .suspend_req(suspend_req)
  );

  // fields: kind(2) 0=write 1=read 3=busy level | addr(19) | data(8) | expected read(8) | expected mode(2) | req(4)
  localparam int NV = 43;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 19'h00555, 8'hAA, 8'h00, 2'd0, 4'd3},  // R3 unlock 1
    {2'd0, 19'h002AA, 8'h55, 8'h00, 2'd0, 4'd3},  // R3 unlock 2
    {2'd0, 19'h00000, 8'h90, 8'h00, 2'd1, 4'd3},  // R3 enter ident
    {2'd1, 19'h00000, 8'h00, 8'hA7, 2'd1, 4'd4},  // R4 alias 00
    {2'd1, 19'h00004, 8'h00, 8'hA7, 2'd1, 4'd4},  // R4 alias 04
    {2'd1, 19'h00008, 8'h00, 8'hA7, 2'd1, 4'd4},  // R4 alias 08
    {2'd1, 19'h0000C, 8'h00, 8'hA7, 2'd1, 4'd4},  // R4 alias 0C
    {2'd1, 19'h00001, 8'h00, 8'h3E, 2'd1, 4'd4},  // R4 device
    {2'd1, 19'h20002, 8'h00, 8'h01, 2'd1, 4'd5},  // R5 sector 2 protected
    {2'd1, 19'h30002, 8'h00, 8'h00, 2'd1, 4'd5},  // R5 sector 3 open
    {2'd1, 19'h50002, 8'h00, 8'h01, 2'd1, 4'd5},  // R5 sector 5 protected
    {2'd1, 19'h00003, 8'h00, 8'h00, 2'd1, 4'd5},  // R5 unused offset
    {2'd0, 19'h00000, 8'h12, 8'h00, 2'd1, 4'd6},  // R6 stray write ignored
    {2'd1, 19'h00000, 8'h00, 8'hA7, 2'd1, 4'd3},  // R3 repeat read
    {2'd0, 19'h00123, 8'hF0, 8'h00, 2'd0, 4'd6},  // R6 bare reset
    {2'd1, 19'h00010, 8'h00, 8'h4A, 2'd0, 4'd2},  // R2 array read
    {2'd0, 19'h00555, 8'hAA, 8'h00, 2'd0, 4'd7},
    {2'd0, 19'h002AA, 8'h54, 8'h00, 2'd0, 4'd7},  // R7 bad data
    {2'd0, 19'h00000, 8'h90, 8'h00, 2'd0, 4'd7},  // R7 no command after abort
    {2'd1, 19'h00011, 8'h00, 8'h4B, 2'd0, 4'd7},  // R7 still array
    {2'd0, 19'h00555, 8'hAA, 8'h00, 2'd0, 4'd3},
    {2'd0, 19'h002AA, 8'h55, 8'h00, 2'd0, 4'd3},
    {2'd0, 19'h00000, 8'h90, 8'h00, 2'd1, 4'd3},
    {2'd0, 19'h00555, 8'hAA, 8'h00, 2'd1, 4'd7},
    {2'd0, 19'h002AB, 8'h55, 8'h00, 2'd0, 4'd7},  // R7 bad address
    {2'd0, 19'h00555, 8'hAA, 8'h00, 2'd0, 4'd8},
    {2'd0, 19'h002AA, 8'h55, 8'h00, 2'd0, 4'd8},
    {2'd0, 19'h00555, 8'h80, 8'h00, 2'd0, 4'd8},
    {2'd0, 19'h00555, 8'hAA, 8'h00, 2'd0, 4'd8},
    {2'd0, 19'h002AA, 8'h55, 8'h00, 2'd0, 4'd8},
    {2'd0, 19'h60000, 8'h30, 8'h00, 2'd2, 4'd8},  // R8 erase begins
    {2'd3, 19'h00000, 8'h01, 8'h00, 2'd2, 4'd12},
    {2'd1, 19'h00000, 8'h00, 8'h00, 2'd2, 4'd9},  // R9 status
    {2'd1, 19'h00000, 8'h00, 8'h40, 2'd2, 4'd9},
    {2'd1, 19'h00000, 8'h00, 8'h00, 2'd2, 4'd9},
    {2'd0, 19'h00000, 8'h30, 8'h00, 2'd2, 4'd11}, // R11 resume ignored
    {2'd0, 19'h7FFFF, 8'hB0, 8'h00, 2'd3, 4'd10}, // R10 suspend
    {2'd1, 19'h00021, 8'h00, 8'h7B, 2'd3, 4'd10}, // R10 array in suspend
    {2'd0, 19'h01234, 8'h30, 8'h00, 2'd2, 4'd11}, // R11 resume
    {2'd0, 19'h00000, 8'h30, 8'h00, 2'd2, 4'd11},
    {2'd0, 19'h00000, 8'hB0, 8'h00, 2'd3, 4'd11}, // R11 suspend again
    {2'd0, 19'h00000, 8'h30, 8'h00, 2'd2, 4'd11},
    {2'd3, 19'h00000, 8'h00, 8'h00, 2'd0, 4'd12}  // R12 busy falls
  };

  task automatic chk(input int req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "mode", mode, 0);
    chk(1, "rd_valid", rd_valid, 0);
    chk(1, "rdata", rdata, 0);
    chk(1, "erase_go", erase_go, 0);
    chk(1, "suspend_req", suspend_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      addr = v[40:22]; wdata = v[21:14];
      case (v[42:41])
        2'd0: wr_en = 1'b1;
        2'd1: rd_en = 1'b1;
        default: busy = v[14];
      endcase
      @(negedge clk);
      wr_en = 1'b0;
      if (v[42:41] == 2'd1) begin
        rd_en = 1'b0;
        chk(v[3:0], "rd_valid", rd_valid, 1);
        chk(v[3:0], "rdata", rdata, v[13:6]);
      end
      chk(v[3:0], "mode", mode, v[5:4]);
    end

    // R8 start pulse and sector, R11 duplicate resume
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'h80);
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h5ABCD, 8'h30);
    chk(8, "erase_go", erase_go, 1);
    chk(8, "erase_sector", erase_sector, 5);
    chk(8, "mode", mode, 2);
    @(negedge clk);
    chk(8, "erase_go second cycle", erase_go, 0);
    chk(10, "suspend_req erasing", suspend_req, 0);
    wr(19'h00000, 8'hB0);
    chk(10, "suspend_req", suspend_req, 1);
    wr(19'h00000, 8'h30);
    chk(11, "suspend_req after resume", suspend_req, 0);
    chk(11, "erase_go on resume", erase_go, 0);
    wr(19'h00000, 8'h30);
    chk(11, "erase_go dup resume", erase_go, 0);
    chk(11, "mode dup resume", mode, 2);

    // R1 reset during erase
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(1, "mode after reset", mode, 0);
    chk(1, "suspend_req after reset", suspend_req, 0);
    addr = 19'h00001; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(2, "array after reset", rdata, 8'h5B);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule